// File: doc/BRIEF.md
# Shared Enable and Status Interrupt Register

This block gathers a small, parameterised group of interrupt sources into one level-sensitive request line for a parent interrupt controller. Software sees a single 32-bit register. The lower half holds one enable bit per source. The upper half holds one pending bit per source, and each pending bit sits exactly sixteen positions above the enable bit of the same source. A rising edge on a source input latches its pending bit. The combined request is raised while any source has both its pending bit and its enable bit set.

Pending bits are cleared by writing a one. A zero leaves them untouched, so one write can change the enables without disturbing any pending event. Software services the active sources from the lowest bit upward and clears each pending bit after it has handled it. The enable field may start at any bit of the lower half (parameter `EN_LSB`). The register answers at one configurable byte address. The default build has seven sources starting at bit 0, at address 0x018. Other builds use six sources at bit 0, or two sources starting at bit 4, each at its own address.

Top module: `irq_status_agg`

## Requirements
- R1: After reset every enable bit and every pending bit is zero, the register reads 0, and `irq_o` is low.
- R2: A rising edge on `src_i[n]` sets the pending bit at register bit 16+EN_LSB+n at the next clock edge, whether or not source n is enabled. A source held high does not set the bit again after it has been cleared.
- R3: A write to the register address loads the enable bits at register bits EN_LSB+n from the write data, all in the same write.
- R4: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged.
- R5: When a new edge and a write-1-to-clear reach the same pending bit in the same cycle, the bit stays set.
- R6: `irq_o` is registered. It is high in the cycle after any source has both its pending and enable bits set, and low in the cycle after no source does.
- R7: Clearing an enable hides the pending bit from `irq_o` but keeps the bit. Setting the enable again raises `irq_o`.
- R8: Bits outside the enable field and its mirrored pending field read as 0 and ignore writes. A read at any other address returns 0, and a write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source inputs, synchronous to clk, latched on rising edge |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | 32 | Read data for the current address (combinational) |
| irq_o | output | 1 | Combined level-sensitive interrupt request |

## Verification
The assertions check on every cycle the rules for a single pending bit: an edge sets it, a lone clear drops it, the edge wins when both arrive together, and with neither the bit holds. They also check that enables load on a register hit and stay stable on writes elsewhere, and that `irq_o` follows the enabled-pending set with one register of delay. Some behaviour only shows up across sequences of accesses, and the bench scenarios cover it: a level held high does not re-arm the bit after a clear, a write of zeros to the status half keeps pending bits, a masked event survives until it is unmasked, and bits outside the fields read back as zero.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int REG_W    = 32;
  localparam int HALF_W   = 16;
  localparam int STAT_OFS = 16;

  function automatic logic [HALF_W-1:0] low_half(input logic [REG_W-1:0] w);
    return w[HALF_W-1:0];
  endfunction

  function automatic logic [HALF_W-1:0] high_half(input logic [REG_W-1:0] w);
    return w[REG_W-1:STAT_OFS];
  endfunction

  function automatic logic [REG_W-1:0] join_halves(input logic [HALF_W-1:0] en_h,
                                                   input logic [HALF_W-1:0] st_h);
    return {st_h, en_h};
  endfunction
endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/irqagg_pend_cell.sv
module irqagg_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end

  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_o);
  assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i) |=> pend_o);
  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(pend_o));
endmodule

// File: rtl/irqagg_regif.sv
module irqagg_regif
  import irqagg_pkg::*;
#(
  parameter int          NUM_SRC    = 7,
  parameter int          EN_LSB     = 0,
  parameter int          ADDR_W     = 12,
  parameter int unsigned REG_OFFSET = 'h018
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] en_q_i,
  input  logic [NUM_SRC-1:0] pend_q_i,
  output logic               wr_hit_o,
  output logic [NUM_SRC-1:0] en_wr_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [REG_W-1:0]   rdata_o
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

  logic              hit;
  logic [HALF_W-1:0] wr_lo, wr_hi;
  logic [HALF_W-1:0] rd_lo, rd_hi;

  assign hit      = (addr_i == HIT_ADDR);
  assign wr_hit_o = hit & we_i;
  assign wr_lo    = low_half(wdata_i);
  assign wr_hi    = high_half(wdata_i);
  assign en_wr_o  = wr_lo[EN_LSB +: NUM_SRC];
  assign clr_o    = wr_hit_o ? wr_hi[EN_LSB +: NUM_SRC] : '0;

  always_comb begin
    rd_lo = '0;
    rd_hi = '0;
    rd_lo[EN_LSB +: NUM_SRC] = en_q_i;
    rd_hi[EN_LSB +: NUM_SRC] = pend_q_i;
  end

  assign rdata_o = hit ? join_halves(rd_lo, rd_hi) : '0;
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irqagg_pkg::*;
#(
  parameter int          NUM_SRC    = 7,
  parameter int          EN_LSB     = 0,
  parameter int          ADDR_W     = 12,
  parameter int unsigned REG_OFFSET = 'h018
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  input  logic               reg_we_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_o
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] en_wr;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] active;
  logic               wr_hit;
  logic               any_active;
  logic               irq_q;

  irqagg_edge #(.WIDTH(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (src_i),
    .rise_o (rise)
  );

  irqagg_regif #(
    .NUM_SRC    (NUM_SRC),
    .EN_LSB     (EN_LSB),
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
  ) u_regif (
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .we_i     (reg_we_i),
    .en_q_i   (en_q),
    .pend_q_i (pend_q),
    .wr_hit_o (wr_hit),
    .en_wr_o  (en_wr),
    .clr_o    (clr),
    .rdata_o  (reg_rdata_o)
  );

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_pend
    irqagg_pend_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (rise[n]),
      .clr_i  (clr[n]),
      .pend_o (pend_q[n])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_hit) en_q <= en_wr;
  end

  assign active     = pend_q & en_q;
  assign any_active = |active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_active;
  end

  assign irq_o = irq_q;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0 && pend_q == '0 && !irq_o));
  assert_enable_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (en_q == $past(en_wr)));
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_active |=> irq_o);
  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !any_active |=> !irq_o);
  assert_masked_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && clr == '0) |=> ($past(pend_q) & ~pend_q) == '0);
  assert_foreign_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i != HIT_ADDR) |=> $stable(en_q));
endmodule

// File: tb/irq_status_agg_tb.sv
`timescale 1ns/1ps
module irq_status_agg_tb_top;
  localparam int N   = 7;
  localparam int SH  = 0;
  localparam logic [11:0] RA = 12'h018;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic [11:0] addr = RA;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_status_agg dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_we_i(we), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  int unsigned m_en, m_pend, m_prev, m_rise, m_clr;
  bit m_irq;
  int unsigned msk;
  initial msk = (1 << N) - 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pend = 0; m_prev = 0; m_irq = 0;
    end else begin
      m_rise = src & ~m_prev & msk;
      m_clr  = 0;
      m_irq  = ((m_pend & m_en) != 0);
      if (we && addr == RA) begin
        m_clr = (wdata >> (16 + SH)) & msk;
        m_en  = (wdata >> SH) & msk;
      end
      m_pend = m_rise | (m_pend & ~m_clr);
      m_prev = src;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    logic [31:0] e;
    #2;
    e = (addr == RA) ? ((m_en << SH) | (m_pend << (16 + SH))) : 32'h0;
    chk({31'h0, irq}, {31'h0, m_irq}, "R6 model irq");
    chk(rdata & 32'h0000_FFFF & (msk << SH), e & 32'h0000_FFFF, "R3 model enables");
    chk(rdata & (msk << (16 + SH)), e & 32'hFFFF_0000, "R2 model status");
    chk(rdata & ~((msk << SH) | (msk << (16 + SH))), 32'h0, "R8 model stray bits");
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = RA;
  endtask

  task automatic pulse(input logic [N-1:0] s);
    @(negedge clk); src = s;
    @(negedge clk); src = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    addr = a; #1; chk(rdata, exp, tag); addr = RA;
  endtask

  task automatic irq_is(input logic exp, input string tag);
    #1; chk({31'h0, irq}, {31'h0, exp}, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rd(RA, 32'h0, "R1 reset read");
    irq_is(1'b0, "R1 reset irq");
    rst_n = 1'b1;
    tick();
    rd(RA, 32'h0, "R1 after release");

    // basic enable, event, delay
    wr(RA, 32'h0000_007F);
    rd(RA, 32'h0000_007F, "R3 enable load");
    pulse(7'h01);
    rd(RA, 32'h0001_007F, "R2 edge sets bit 16");
    irq_is(1'b0, "R6 one-cycle delay");
    tick();
    irq_is(1'b1, "R6 irq raised");

    // clear while keeping enables
    wr(RA, 32'h0001_007F);
    rd(RA, 32'h0000_007F, "R4 w1c clears");
    irq_is(1'b1, "R6 irq still high one cycle");
    tick();
    irq_is(1'b0, "R6 irq dropped");

    // zeros in status half keep pending
    pulse(7'h02);
    wr(RA, 32'h0000_007F);
    rd(RA, 32'h0002_007F, "R4 zero write keeps");
    wr(RA, 32'h0002_007F);
    rd(RA, 32'h0000_007F, "R4 second clear");

    // masked event retained
    wr(RA, 32'h0);
    pulse(7'h08);
    rd(RA, 32'h0008_0000, "R2 edge sets while disabled");
    tick();
    irq_is(1'b0, "R7 masked irq low");
    wr(RA, 32'h0000_0008);
    rd(RA, 32'h0008_0008, "R7 bit kept");
    tick();
    irq_is(1'b1, "R7 unmask raises irq");
    wr(RA, 32'h0008_0000);
    rd(RA, 32'h0, "R4 clear and disable");
    tick();
    irq_is(1'b0, "R6 low after clear");

    // collision: edge and clear on same bit
    pulse(7'h20);
    rd(RA, 32'h0020_0000, "R5 pending before");
    @(negedge clk); src = 7'h20; addr = RA; wdata = 32'h0020_0000; we = 1'b1;
    @(negedge clk); we = 1'b0; src = '0;
    rd(RA, 32'h0020_0000, "R5 edge wins");
    wr(RA, 32'h0020_0000);
    rd(RA, 32'h0, "R5 later clear");

    // held level does not re-arm
    @(negedge clk); src = 7'h04;
    tick();
    rd(RA, 32'h0004_0000, "R2 level edge");
    wr(RA, 32'h0004_0000);
    rd(RA, 32'h0, "R2 held high no re-set");
    tick(); tick();
    rd(RA, 32'h0, "R2 held high still clear");
    src = '0;

    // all sources, foreign address, stray bits
    wr(RA, 32'hFFFF_FFFF);
    rd(RA, 32'h0000_007F, "R8 stray enable bits read zero");
    pulse(7'h7F);
    rd(RA, 32'h007F_007F, "R2 all sources");
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h01C, 32'h0, "R8 other address reads zero");
    rd(RA, 32'h007F_007F, "R8 other address write ignored");
    wr(RA, 32'hFF80_FF80);
    rd(RA, 32'h007F_0000, "R8 stray writes ignored");
    tick();
    irq_is(1'b0, "R7 all masked");
    wr(RA, 32'h007F_0000);
    rd(RA, 32'h0, "R4 clear all");
    tick(); tick();

    done = 1;
    summary();
    $finish;
  end
endmodule